// File: doc/BRIEF.md
# Timer0 and Watchdog with a Shared Prescaler

This block pairs an 8-bit timer/counter with a watchdog. The two share a single 8-stage ripple prescaler. The timer advances on the internal instruction-cycle clock, or on a chosen edge of an external pin. The watchdog advances on ticks from a slow oscillator, which is outside the block and arrives here as a one-cycle tick input. An option register selects the count source and the pin edge. One bit of the same register routes the prescaler either in front of the timer or behind the watchdog. A 3-bit code sets the ratio.

When the timer rolls over it raises a sticky overflow flag, which software clears. When the watchdog expires it drives a one-cycle reset request and clears a time-out status flag, which is active low. A clear-watchdog strobe or a sleep strobe restarts the watchdog and sets that flag again. Two further option bits are passed through to the port logic: the pull-up disable and the pin-interrupt edge. In this block each clock cycle is one instruction cycle.

Top module: `timer_wdog`

## Requirements
- R1: After reset, `opt_q` is FFh, `tmr_q` is 0, `ovf_flag` is 0, `wdt_bite` is 0 and `tf_n` is 1.
- R2: With option bit 5 = 0 and option bit 3 = 1, `tmr_q` rises by one every clock cycle.
- R3: With option bit 3 = 0, the prescaler drives the timer, and code n in option bits 2..0 gives one timer increment per 2^(n+1) source events.
- R4: With option bit 5 = 1, the timer counts edges of `ext_pin` after a two-flop synchroniser. Option bit 4 = 0 selects rising edges and 1 selects falling edges. Each counted edge shows on `tmr_q` at the third rising clock edge after the pin changes.
- R5: A wrap of the timer from FFh to 00h sets `ovf_flag` on the same edge. The flag stays set until `ovf_clr` clears it. If a wrap and `ovf_clr` fall in the same cycle, the set takes priority.
- R6: A write on the timer port loads `tmr_wdata`. It clears the prescaler when the prescaler serves the timer. The timer then does not count in the two cycles after the write.
- R7: The watchdog expires after WDOG_LIMIT watchdog events. A watchdog event is every `wdt_tick` when option bit 3 = 0, and one per 2^n ticks when option bit 3 = 1. On expiry `wdt_bite` pulses high for exactly one cycle and `tf_n` goes to 0.
- R8: `wdt_clr` or `sleep_cmd` restarts the watchdog count, clears the prescaler when it serves the watchdog, and sets `tf_n` to 1.
- R9: A write on the option port shows on `opt_q` one cycle later. Option bit 7 drives `pull_off` and option bit 6 drives `int_rise`.
- R10: An option write that changes bit 3 clears the prescaler count. An event in that same cycle produces no prescaler output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one instruction cycle |
| rst | input | 1 | Synchronous active-high reset |
| opt_we | input | 1 | Option register write strobe |
| opt_wdata | input | 8 | Option register write data |
| opt_q | output | 8 | Option register contents |
| tmr_we | input | 1 | Timer write strobe |
| tmr_wdata | input | TMR_W | Timer write data |
| tmr_q | output | TMR_W | Timer count |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky timer overflow flag |
| ext_pin | input | 1 | External count pin (asynchronous) |
| wdt_tick | input | 1 | One-cycle tick from the watchdog oscillator |
| wdt_clr | input | 1 | Clear-watchdog command strobe |
| sleep_cmd | input | 1 | Sleep command strobe |
| wdt_bite | output | 1 | One-cycle watchdog time-out reset request |
| tf_n | output | 1 | Time-out status flag, low after an expiry |
| pull_off | output | 1 | Pull-up disable (option bit 7) |
| int_rise | output | 1 | Pin-interrupt edge select, 1 = rising (option bit 6) |

## Verification
The latency of each result is fixed:
- An option write shows one rising edge later.
- A timer write loads on its own edge, then holds through the next two edges.
- Internal counting then advances on every following edge, or on every 2^(n+1)-th edge when the prescaler serves the timer.
- A pin change appears on `tmr_q` at the third edge.
- The overflow flag and the watchdog bite change on the same edge as the event that causes them.

The bench drives every input on the falling clock edge. It counts rising edges from that point before it samples, again on a falling edge. A behavioural model, updated on every rising edge from the same inputs, is compared with all outputs on each falling edge.

// File: rtl/twc_pkg.sv
package twc_pkg;

    localparam int PS_W       = 3;
    localparam int PRE_W      = 8;
    localparam int WR_HOLD    = 2;
    localparam int SYNC_STAGE = 2;
    localparam logic [7:0] OPT_RESET = 8'hFF;

    // Field order follows the register bit order (bit 7 first).
    typedef struct packed {
        logic            pull_off;
        logic            int_rise;
        logic            ext_src;
        logic            fall_edge;
        logic            to_wdog;
        logic [PS_W-1:0] ps;
    } opt_t;

    typedef enum logic {
        ROUTE_TMR  = 1'b0,
        ROUTE_WDOG = 1'b1
    } route_e;

    localparam logic [PRE_W:0] MASK_ONE = {{PRE_W{1'b0}}, 1'b1};

    // Low bits of the prescaler that must all be ones for it to emit.
    function automatic logic [PRE_W-1:0] tap_mask(input logic [PS_W-1:0] ps,
                                                  input route_e route);
        logic [PRE_W:0] m;
        int             sh;
        sh = int'(ps) + ((route == ROUTE_WDOG) ? 0 : 1);
        m  = (MASK_ONE << sh) - MASK_ONE;
        return m[PRE_W-1:0];
    endfunction

endpackage

// File: rtl/twc_pin_edge.sv
module twc_pin_edge
    import twc_pkg::*;
#(
    parameter int STAGES = SYNC_STAGE
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic fall_sel,
    output logic hit
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[SH_W-2:0], pin};
    end

    // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value.
    assign hit = fall_sel ? (sh[STAGES] & ~sh[STAGES-1])
                          : (sh[STAGES-1] & ~sh[STAGES]);
endmodule

// File: rtl/twc_prescaler.sv
module twc_prescaler
    import twc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            evt,
    input  logic [PS_W-1:0] ps,
    input  route_e          route,
    output logic            fire
);
    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] mask;

    assign mask = tap_mask(ps, route);
    assign fire = evt & ~clr & ((cnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (evt)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/twc_watchdog.sv
module twc_watchdog #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic evt,
    output logic bite,
    output logic tf_n
);
    localparam int             CW   = $clog2(LIMIT + 1);
    localparam logic [CW-1:0]  LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt  <= '0;
            bite <= 1'b0;
            tf_n <= 1'b1;
        end else if (evt && cnt == LAST) begin
            cnt  <= '0;
            bite <= 1'b1;
            tf_n <= 1'b0;
        end else begin
            bite <= 1'b0;
            if (evt) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/timer_wdog.sv
module timer_wdog
    import twc_pkg::*;
#(
    parameter int TMR_W      = 8,
    parameter int WDOG_LIMIT = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             opt_we,
    input  logic [7:0]       opt_wdata,
    output logic [7:0]       opt_q,
    input  logic             tmr_we,
    input  logic [TMR_W-1:0] tmr_wdata,
    output logic [TMR_W-1:0] tmr_q,
    input  logic             ovf_clr,
    output logic             ovf_flag,
    input  logic             ext_pin,
    input  logic             wdt_tick,
    input  logic             wdt_clr,
    input  logic             sleep_cmd,
    output logic             wdt_bite,
    output logic             tf_n,
    output logic             pull_off,
    output logic             int_rise
);
    localparam int HOLD_W = $clog2(WR_HOLD + 1);
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(WR_HOLD);

    logic [7:0]        opt_r;
    opt_t              opt;
    route_e            route;
    logic [HOLD_W-1:0] hold;
    logic [TMR_W-1:0]  tmr_r;
    logic              ovf_r;

    logic pin_hit, src_evt, tmr_raw, restart;
    logic pre_clr, pre_evt, pre_fire, tmr_inc, wdog_evt;

    assign opt   = opt_t'(opt_r);
    assign route = route_e'(opt.to_wdog);

    always_ff @(posedge clk) begin
        if (rst)         opt_r <= OPT_RESET;
        else if (opt_we) opt_r <= opt_wdata;
    end

    twc_pin_edge #(.STAGES(SYNC_STAGE)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .pin      (ext_pin),
        .fall_sel (opt.fall_edge),
        .hit      (pin_hit)
    );

    assign src_evt = opt.ext_src ? pin_hit : 1'b1;
    assign tmr_raw = src_evt & (hold == '0) & ~tmr_we;
    assign restart = wdt_clr | sleep_cmd;

    assign pre_clr = (opt_we && (opt_wdata[3] != opt.to_wdog))
                   || (route == ROUTE_TMR  && tmr_we)
                   || (route == ROUTE_WDOG && restart);
    assign pre_evt = (route == ROUTE_WDOG) ? wdt_tick : tmr_raw;

    twc_prescaler u_pre (
        .clk   (clk),
        .rst   (rst),
        .clr   (pre_clr),
        .evt   (pre_evt),
        .ps    (opt.ps),
        .route (route),
        .fire  (pre_fire)
    );

    assign tmr_inc  = (route == ROUTE_WDOG) ? tmr_raw  : pre_fire;
    assign wdog_evt = (route == ROUTE_WDOG) ? pre_fire : wdt_tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_r <= '0;
            hold  <= '0;
        end else if (tmr_we) begin
            tmr_r <= tmr_wdata;
            hold  <= HOLD_LOAD;
        end else begin
            if (tmr_inc)      tmr_r <= tmr_r + 1'b1;
            if (hold != '0)   hold  <= hold - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                  ovf_r <= 1'b0;
        else if (tmr_inc && !tmr_we && &tmr_r)    ovf_r <= 1'b1;
        else if (ovf_clr)                         ovf_r <= 1'b0;
    end

    twc_watchdog #(.LIMIT(WDOG_LIMIT)) u_wdog (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .evt     (wdog_evt),
        .bite    (wdt_bite),
        .tf_n    (tf_n)
    );

    assign opt_q    = opt_r;
    assign tmr_q    = tmr_r;
    assign ovf_flag = ovf_r;
    assign pull_off = opt.pull_off;
    assign int_rise = opt.int_rise;
endmodule

// File: rtl/timer_wdog_chk.sv
module timer_wdog_chk #(
    parameter int TMR_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             opt_we,
    input logic [7:0]       opt_wdata,
    input logic [7:0]       opt_q,
    input logic             tmr_we,
    input logic [TMR_W-1:0] tmr_wdata,
    input logic [TMR_W-1:0] tmr_q,
    input logic             ovf_flag,
    input logic             wdt_clr,
    input logic             sleep_cmd,
    input logic             wdt_bite,
    input logic             tf_n
);
    a_r5_wrap_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (tmr_q == '0 && $past(tmr_q) == '1 && !$past(tmr_we) && !$past(rst)) |-> ovf_flag);

    a_r6_write_loads: assert property (@(posedge clk) disable iff (rst)
        $past(tmr_we) |-> (tmr_q == $past(tmr_wdata)));

    a_r6_write_holds: assert property (@(posedge clk) disable iff (rst)
        ($past(tmr_we, 2) && !$past(tmr_we) && !$past(rst, 2)) |-> $stable(tmr_q));

    a_r7_bite_single: assert property (@(posedge clk) disable iff (rst)
        wdt_bite |=> !wdt_bite);

    a_r7_bite_flags: assert property (@(posedge clk) disable iff (rst)
        wdt_bite |-> !tf_n);

    a_r8_restart: assert property (@(posedge clk) disable iff (rst)
        (wdt_clr || sleep_cmd) |=> (tf_n && !wdt_bite));

    a_r9_opt_write: assert property (@(posedge clk) disable iff (rst)
        opt_we |=> (opt_q == $past(opt_wdata)));
endmodule

bind timer_wdog timer_wdog_chk #(.TMR_W(TMR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .opt_we    (opt_we),
    .opt_wdata (opt_wdata),
    .opt_q     (opt_q),
    .tmr_we    (tmr_we),
    .tmr_wdata (tmr_wdata),
    .tmr_q     (tmr_q),
    .ovf_flag  (ovf_flag),
    .wdt_clr   (wdt_clr),
    .sleep_cmd (sleep_cmd),
    .wdt_bite  (wdt_bite),
    .tf_n      (tf_n)
);

// File: tb/timer_wdog_tb_top.sv
`timescale 1ns/1ps
module timer_wdog_tb_top;
    localparam int LIM = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       opt_we = 0, tmr_we = 0, ovf_clr = 0, ext_pin = 0;
    logic       wdt_tick = 0, wdt_clr = 0, sleep_cmd = 0;
    logic [7:0] opt_wdata = 0, tmr_wdata = 0;
    logic [7:0] opt_q, tmr_q;
    logic       ovf_flag, wdt_bite, tf_n, pull_off, int_rise;

    int n_chk = 0;
    int n_fail = 0;
    bit model_on = 0;

    always #2 clk = ~clk;

    timer_wdog #(.TMR_W(8), .WDOG_LIMIT(LIM)) dut_i (
        .clk(clk), .rst(rst), .opt_we(opt_we), .opt_wdata(opt_wdata), .opt_q(opt_q),
        .tmr_we(tmr_we), .tmr_wdata(tmr_wdata), .tmr_q(tmr_q),
        .ovf_clr(ovf_clr), .ovf_flag(ovf_flag), .ext_pin(ext_pin),
        .wdt_tick(wdt_tick), .wdt_clr(wdt_clr), .sleep_cmd(sleep_cmd),
        .wdt_bite(wdt_bite), .tf_n(tf_n), .pull_off(pull_off), .int_rise(int_rise)
    );

    // Behavioural reference model
    bit [7:0] m_opt;
    int       m_tmr, m_pre, m_hold, m_wcnt;
    bit       m_flag, m_bite, m_tf, m_s1, m_s2, m_s3;
    bit       b_psa, b_pe, b_src, b_raw, b_clr, b_pevt, b_fire, b_tinc, b_wevt;
    int       b_ratio;

    always @(posedge clk) begin
        if (rst) begin
            m_opt = 8'hFF; m_tmr = 0; m_pre = 0; m_hold = 0; m_wcnt = 0;
            m_flag = 0; m_bite = 0; m_tf = 1; m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            b_psa   = m_opt[3];
            b_pe    = m_opt[4] ? (m_s3 && !m_s2) : (m_s2 && !m_s3);
            b_src   = m_opt[5] ? b_pe : 1'b1;
            b_raw   = b_src && (m_hold == 0) && !tmr_we;
            b_clr   = (opt_we && (opt_wdata[3] != b_psa)) || (!b_psa && tmr_we)
                      || (b_psa && (wdt_clr || sleep_cmd));
            b_pevt  = b_psa ? wdt_tick : b_raw;
            b_ratio = b_psa ? (1 << m_opt[2:0]) : (2 << m_opt[2:0]);
            b_fire  = b_pevt && !b_clr && (((m_pre + 1) % b_ratio) == 0);
            b_tinc  = b_psa ? b_raw : b_fire;
            b_wevt  = b_psa ? b_fire : wdt_tick;
            if (b_clr) m_pre = 0; else if (b_pevt) m_pre = (m_pre + 1) % 256;
            if (b_tinc && !tmr_we && m_tmr == 255) m_flag = 1;
            else if (ovf_clr) m_flag = 0;
            if (tmr_we) begin
                m_tmr = tmr_wdata; m_hold = 2;
            end else begin
                if (b_tinc) m_tmr = (m_tmr + 1) % 256;
                if (m_hold > 0) m_hold--;
            end
            if (wdt_clr || sleep_cmd) begin
                m_wcnt = 0; m_tf = 1; m_bite = 0;
            end else if (b_wevt && m_wcnt == LIM - 1) begin
                m_wcnt = 0; m_tf = 0; m_bite = 1;
            end else begin
                m_bite = 0;
                if (b_wevt) m_wcnt++;
            end
            if (opt_we) m_opt = opt_wdata;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (model_on && !rst) begin
            chk("R3 model tmr_q", 32'(tmr_q), 32'(m_tmr));
            chk("R5 model ovf_flag", 32'(ovf_flag), 32'(m_flag));
            chk("R7 model wdt_bite", 32'(wdt_bite), 32'(m_bite));
            chk("R8 model tf_n", 32'(tf_n), 32'(m_tf));
            chk("R9 model opt_q", 32'(opt_q), 32'(m_opt));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_opt(input logic [7:0] v);
        opt_we = 1; opt_wdata = v; cyc(1); opt_we = 0;
    endtask

    task automatic wr_tmr(input logic [7:0] v);
        tmr_we = 1; tmr_wdata = v; cyc(1); tmr_we = 0;
    endtask

    task automatic tick();
        wdt_tick = 1; cyc(1); wdt_tick = 0; cyc(1);
    endtask

    task automatic pulse_clr();
        wdt_clr = 1; cyc(1); wdt_clr = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        cyc(3);
        // R1 reset values
        chk("R1 opt_q", 32'(opt_q), 32'hFF);
        chk("R1 tmr_q", 32'(tmr_q), 32'h0);
        chk("R1 ovf_flag", 32'(ovf_flag), 32'h0);
        chk("R1 wdt_bite", 32'(wdt_bite), 32'h0);
        chk("R1 tf_n", 32'(tf_n), 32'h1);
        rst = 0;
        model_on = 1;
        cyc(1);

        // R2 and R6: internal count, no prescaler
        wr_opt(8'h08);
        wr_tmr(8'h10);
        cyc(2);
        chk("R6 hold after write", 32'(tmr_q), 32'h10);
        cyc(8);
        chk("R2 internal count", 32'(tmr_q), 32'h18);

        // R3: prescaler on timer, ratio 1:4
        wr_opt(8'h01);
        wr_tmr(8'h40);
        cyc(13);
        chk("R3 ratio before tap", 32'(tmr_q), 32'h42);
        cyc(1);
        chk("R3 ratio at tap", 32'(tmr_q), 32'h43);

        // R5: overflow flag
        ovf_clr = 1; cyc(1); ovf_clr = 0;
        wr_opt(8'h08);
        wr_tmr(8'hFE);
        cyc(3);
        chk("R5 tmr at FF", 32'(tmr_q), 32'hFF);
        chk("R5 flag before wrap", 32'(ovf_flag), 32'h0);
        cyc(1);
        chk("R5 tmr wrapped", 32'(tmr_q), 32'h00);
        chk("R5 flag set", 32'(ovf_flag), 32'h1);
        ovf_clr = 1; cyc(1); ovf_clr = 0;
        chk("R5 flag cleared", 32'(ovf_flag), 32'h0);

        // R4: external pin edges
        wr_opt(8'h28);
        wr_tmr(8'h00);
        cyc(4);
        ext_pin = 1;
        cyc(2);
        chk("R4 rise not yet", 32'(tmr_q), 32'h0);
        cyc(1);
        chk("R4 rise counted", 32'(tmr_q), 32'h1);
        ext_pin = 0;
        cyc(5);
        chk("R4 fall ignored", 32'(tmr_q), 32'h1);
        wr_opt(8'h38);
        cyc(2);
        ext_pin = 1;
        cyc(5);
        chk("R4 rise ignored", 32'(tmr_q), 32'h1);
        ext_pin = 0;
        cyc(3);
        chk("R4 fall counted", 32'(tmr_q), 32'h2);

        // R10: assignment change clears prescaler
        wr_opt(8'h01);
        wr_tmr(8'h00);
        cyc(4);
        wr_opt(8'h09);
        wr_opt(8'h01);
        cyc(3);
        chk("R10 before tap", 32'(tmr_q), 32'h1);
        cyc(1);
        chk("R10 tap after clear", 32'(tmr_q), 32'h2);

        // R7: watchdog without prescaler
        wr_opt(8'h00);
        pulse_clr();
        repeat (15) tick();
        chk("R7 no bite yet", 32'(wdt_bite), 32'h0);
        chk("R7 tf_n still high", 32'(tf_n), 32'h1);
        wdt_tick = 1; cyc(1);
        chk("R7 bite", 32'(wdt_bite), 32'h1);
        chk("R7 tf_n cleared", 32'(tf_n), 32'h0);
        wdt_tick = 0; cyc(1);
        chk("R7 bite one cycle", 32'(wdt_bite), 32'h0);

        // R8: restart commands
        pulse_clr();
        chk("R8 clr sets tf_n", 32'(tf_n), 32'h1);
        repeat (15) tick();
        sleep_cmd = 1; cyc(1); sleep_cmd = 0;
        repeat (15) tick();
        chk("R8 sleep restarted", 32'(tf_n), 32'h1);

        // R7: watchdog with prescaler 1:2
        wr_opt(8'h09);
        pulse_clr();
        repeat (31) tick();
        chk("R7 scaled no bite", 32'(tf_n), 32'h1);
        wdt_tick = 1; cyc(1);
        chk("R7 scaled bite", 32'(wdt_bite), 32'h1);
        wdt_tick = 0; cyc(1);

        // R9: pass-through option bits
        wr_opt(8'h40);
        chk("R9 opt_q", 32'(opt_q), 32'h40);
        chk("R9 pull_off low", 32'(pull_off), 32'h0);
        chk("R9 int_rise high", 32'(int_rise), 32'h1);
        wr_opt(8'h80);
        chk("R9 pull_off high", 32'(pull_off), 32'h1);
        chk("R9 int_rise low", 32'(int_rise), 32'h0);

        cyc(4);
        finish_run();
    end
endmodule